// File: doc/BRIEF.md
# Configurable Product-Term Macrocell

This block is one programmable cell of a product-term logic array. A shared input bus reaches the cell, and static configuration inputs choose, for each bit, whether the true value, the complemented value or neither value enters each of the cell's two AND terms. The two terms are merged by a selectable OR or XOR. A sum arriving from the neighbouring cell on the expander input is ORed in. The merged sum goes out on the expander output, so that wide sums can be chained across cells. The merged sum then passes through an optional inverter. With the inverter, a wide OR can be built as the complement of an AND of complemented literals.

The cell output is either the combinational function or the output of a register. The register can behave as a D, T, JK or SR flip-flop. It has a clock enable and an active-low asynchronous clear. Setting a preset-emulation bit stores the complement of the visible state. The clear then drives the visible output to 1, and each flip-flop mode still behaves the same as seen at the output. All configuration is meant to be held static while the cell runs.

Top module: `ptm_cell`

## Requirements
- R1: For input bit i, select bits [2i+1:2i] of a term choose the literal: 2'b00 leaves the bit out, 2'b01 uses the true value, 2'b10 uses the complement, and 2'b11 forces the term to 0. A term with every bit left out evaluates to 1.
- R2: `cfg_xor`=0 merges term A and term B by OR. `cfg_xor`=1 merges them by XOR.
- R3: `pexp_in` is ORed into the merged sum. `pexp_out` carries that sum before the inverter.
- R4: `cfg_inv`=1 complements the cell function, and `cfg_inv`=0 passes it unchanged.
- R5: With `cfg_bypass`=1, `mc_out` follows the cell function combinationally. With `cfg_bypass`=0, `mc_out` shows the registered state.
- R6: With `ff_mode`=2'b00 (D), a clock edge with enable loads the cell function.
- R7: With `ff_mode`=2'b01 (T), a clock edge with enable toggles the state when the cell function is 1 and holds it when the function is 0.
- R8: With `ff_mode`=2'b10 (JK), J is term A and K is term B. An edge with enable sets on J=1,K=0, clears on J=0,K=1, toggles on J=K=1 and holds on J=K=0.
- R9: With `ff_mode`=2'b11 (SR), S is term A and R is term B. An edge with enable sets on S=1,R=0 and clears on S=0,R=1. The illegal case S=R=1 holds the state, and so does S=R=0.
- R10: With `ena`=0, a clock edge leaves the registered state unchanged.
- R11: `clr_n`=0 forces the registered output to its cleared value at once, whatever the clock and enable are doing.
- R12: With `cfg_preset`=1, the cleared registered output is 1, and R6 to R9 keep their meaning as seen at `mc_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| clr_n | input | 1 | Asynchronous clear, active low |
| ena | input | 1 | Register clock enable |
| in_bus | input | N_IN | Shared literal inputs |
| sel_a | input | 2*N_IN | Literal selects for term A |
| sel_b | input | 2*N_IN | Literal selects for term B |
| cfg_xor | input | 1 | 1 selects XOR merge, 0 selects OR merge |
| cfg_inv | input | 1 | Output inverter enable |
| cfg_bypass | input | 1 | 1 selects the combinational output |
| cfg_preset | input | 1 | Preset emulation (stored state inverted) |
| ff_mode | input | 2 | Register mode: 00 D, 01 T, 10 JK, 11 SR |
| pexp_in | input | 1 | Expander sum from the neighbouring cell |
| pexp_out | output | 1 | Expander sum to the next cell |
| mc_out | output | 1 | Cell output |

## Verification
The register assertions assume that any pulse on `clr_n` stays low across at least one rising clock edge. A shorter pulse between edges would change the state without being seen as a clocked update. They also assume that the configuration inputs do not change in the same cycle as a register update that is being checked. The stimulus follows both assumptions. Each clear is driven low shortly after a falling edge and released only after the next rising edge. Configuration and data change only at falling edges. The cell function is swept exhaustively over every term select pattern and input value of a 4-bit bus. Each register mode, with preset emulation on and off, runs through a long stream of random data, enable and merge settings.

// File: rtl/ptm_pkg.sv
package ptm_pkg;

   typedef enum logic [1:0] {
      FF_D  = 2'b00,
      FF_T  = 2'b01,
      FF_JK = 2'b10,
      FF_SR = 2'b11
   } ff_mode_e;

   localparam logic [1:0] LIT_NONE = 2'b00;
   localparam logic [1:0] LIT_TRUE = 2'b01;
   localparam logic [1:0] LIT_COMP = 2'b10;
   localparam logic [1:0] LIT_KILL = 2'b11;

   localparam int MAX_IN = 64;

endpackage

// File: rtl/ptm_pterm.sv
module ptm_pterm
   import ptm_pkg::*;
#(
   parameter int N_IN = 8
) (
   input  logic [N_IN-1:0]   lits,
   input  logic [2*N_IN-1:0] sel,
   output logic              term
);

   logic [N_IN-1:0] pass;

   for (genvar i = 0; i < N_IN; i++) begin : g_lit
      logic [1:0] code;
      assign code    = sel[2*i +: 2];
      assign pass[i] = (code == LIT_NONE)
                     | ((code == LIT_TRUE) &  lits[i])
                     | ((code == LIT_COMP) & ~lits[i]);
   end

   assign term = &pass;

endmodule

// File: rtl/ptm_combine.sv
module ptm_combine (
   input  logic term_a,
   input  logic term_b,
   input  logic use_xor,
   input  logic invert,
   input  logic exp_in,
   output logic sum,
   output logic func
);

   logic core;

   always_comb begin
      core = use_xor ? (term_a ^ term_b) : (term_a | term_b);
      sum  = core | exp_in;
      func = sum ^ invert;
   end

endmodule

// File: rtl/ptm_flop.sv
module ptm_flop
   import ptm_pkg::*;
(
   input  logic     clk,
   input  logic     clr_n,
   input  logic     ena,
   input  ff_mode_e mode,
   input  logic     store_inv,
   input  logic     f_in,
   input  logic     a_in,
   input  logic     b_in,
   output logic     q
);

   logic set_s, rst_s, nxt;

   always_comb begin
      set_s = store_inv ? b_in : a_in;
      rst_s = store_inv ? a_in : b_in;
      nxt   = q;
      unique case (mode)
         FF_D:  nxt = f_in ^ store_inv;
         FF_T:  nxt = q ^ f_in;
         FF_JK: begin
            unique case ({set_s, rst_s})
               2'b10:   nxt = 1'b1;
               2'b01:   nxt = 1'b0;
               2'b11:   nxt = ~q;
               default: nxt = q;
            endcase
         end
         FF_SR: begin
            unique case ({set_s, rst_s})
               2'b10:   nxt = 1'b1;
               2'b01:   nxt = 1'b0;
               default: nxt = q;
            endcase
         end
         default: nxt = q;
      endcase
   end

   always_ff @(posedge clk or negedge clr_n) begin
      if (!clr_n)
         q <= 1'b0;
      else if (ena)
         q <= nxt;
   end

endmodule

// File: rtl/ptm_cell.sv
module ptm_cell
   import ptm_pkg::*;
#(
   parameter int N_IN = 8
) (
   input  logic              clk,
   input  logic              clr_n,
   input  logic              ena,
   input  logic [N_IN-1:0]   in_bus,
   input  logic [2*N_IN-1:0] sel_a,
   input  logic [2*N_IN-1:0] sel_b,
   input  logic              cfg_xor,
   input  logic              cfg_inv,
   input  logic              cfg_bypass,
   input  logic              cfg_preset,
   input  logic [1:0]        ff_mode,
   input  logic              pexp_in,
   output logic              pexp_out,
   output logic              mc_out
);

   localparam int SEL_W   = 2 * N_IN;
   localparam int N_TERMS = 2;

   if (N_IN < 1 || N_IN > MAX_IN) begin : g_bad_width
      $error("ptm_cell: N_IN out of range");
   end

   logic [N_TERMS-1:0]            term;
   logic [N_TERMS-1:0][SEL_W-1:0] sel_all;
   logic                          f_out;
   logic                          reg_q;
   ff_mode_e                      mode;

   assign sel_all = {sel_b, sel_a};
   assign mode    = ff_mode_e'(ff_mode);

   for (genvar t = 0; t < N_TERMS; t++) begin : g_term
      ptm_pterm #(.N_IN(N_IN)) u_term (
         .lits (in_bus),
         .sel  (sel_all[t]),
         .term (term[t])
      );
   end

   ptm_combine u_comb (
      .term_a  (term[0]),
      .term_b  (term[1]),
      .use_xor (cfg_xor),
      .invert  (cfg_inv),
      .exp_in  (pexp_in),
      .sum     (pexp_out),
      .func    (f_out)
   );

   ptm_flop u_flop (
      .clk       (clk),
      .clr_n     (clr_n),
      .ena       (ena),
      .mode      (mode),
      .store_inv (cfg_preset),
      .f_in      (f_out),
      .a_in      (term[0]),
      .b_in      (term[1]),
      .q         (reg_q)
   );

   assign mc_out = cfg_bypass ? f_out : (reg_q ^ cfg_preset);

endmodule

// File: rtl/ptm_cell_chk.sv
module ptm_cell_chk
   import ptm_pkg::*;
(
   input logic       clk,
   input logic       clr_n,
   input logic       ena,
   input logic [1:0] ff_mode,
   input logic       cfg_preset,
   input logic       cfg_bypass,
   input logic       term_a,
   input logic       term_b,
   input logic       comb_f,
   input logic       reg_q,
   input logic       pexp_in,
   input logic       pexp_out,
   input logic       mc_out
);

   always_comb begin
      if (pexp_in === 1'b1)
         a_r3_exp_carry: assert (pexp_out === 1'b1);
   end

   always_ff @(posedge clk) begin
      if (clr_n === 1'b0)
         a_r11_clear: assert (reg_q == 1'b0 && (cfg_bypass || mc_out == cfg_preset));
   end

   a_r6_dload: assert property (@(posedge clk) disable iff (!clr_n)
      (ena && ff_mode == FF_D) |=> (reg_q == $past(comb_f ^ cfg_preset)));

   a_r7_toggle: assert property (@(posedge clk) disable iff (!clr_n)
      (ena && ff_mode == FF_T && comb_f) |=> (reg_q != $past(reg_q)));

   a_r8_jk_toggle: assert property (@(posedge clk) disable iff (!clr_n)
      (ena && ff_mode == FF_JK && term_a && term_b) |=> (reg_q != $past(reg_q)));

   a_r9_sr_hold: assert property (@(posedge clk) disable iff (!clr_n)
      (ena && ff_mode == FF_SR && term_a && term_b) |=> $stable(reg_q));

   a_r10_hold: assert property (@(posedge clk) disable iff (!clr_n)
      !ena |=> $stable(reg_q));

endmodule

bind ptm_cell ptm_cell_chk u_chk (
   .clk        (clk),
   .clr_n      (clr_n),
   .ena        (ena),
   .ff_mode    (ff_mode),
   .cfg_preset (cfg_preset),
   .cfg_bypass (cfg_bypass),
   .term_a     (term[0]),
   .term_b     (term[1]),
   .comb_f     (f_out),
   .reg_q      (reg_q),
   .pexp_in    (pexp_in),
   .pexp_out   (pexp_out),
   .mc_out     (mc_out)
);

// File: tb/ptm_cell_tb.sv
`timescale 1ns/1ps
module ptm_cell_tb;

   localparam int N = 4;

   logic         clk = 1'b0;
   logic         clr_n = 1'b0;
   logic         ena = 1'b0;
   logic [N-1:0] in_bus = '0;
   logic [2*N-1:0] sel_a = '0;
   logic [2*N-1:0] sel_b = '0;
   logic         cfg_xor = 1'b0;
   logic         cfg_inv = 1'b0;
   logic         cfg_bypass = 1'b0;
   logic         cfg_preset = 1'b0;
   logic [1:0]   ff_mode = 2'b00;
   logic         pexp_in = 1'b0;
   logic         pexp_out;
   logic         mc_out;

   int n_chk = 0;
   int n_bad = 0;

   always #2.5 clk = ~clk;

   ptm_cell #(.N_IN(N)) u_dut (
      .clk(clk), .clr_n(clr_n), .ena(ena), .in_bus(in_bus),
      .sel_a(sel_a), .sel_b(sel_b), .cfg_xor(cfg_xor), .cfg_inv(cfg_inv),
      .cfg_bypass(cfg_bypass), .cfg_preset(cfg_preset), .ff_mode(ff_mode),
      .pexp_in(pexp_in), .pexp_out(pexp_out), .mc_out(mc_out)
   );

   task automatic chk(input string req, input logic act, input logic exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: got %b expected %b", req, act, exp);
      end
   endtask

   // R1 literal rule, computed bit by bit
   function automatic logic ref_term(input logic [N-1:0] v, input logic [2*N-1:0] s);
      logic r = 1'b1;
      for (int i = 0; i < N; i++) begin
         case (s[2*i +: 2])
            2'b01:   r = r & v[i];
            2'b10:   r = r & ~v[i];
            2'b11:   r = 1'b0;
            default: r = r;
         endcase
      end
      return r;
   endfunction

   function automatic logic ref_next(input logic [1:0] m, input logic q, input logic a,
                                     input logic b, input logic f, input logic en);
      if (!en) return q;
      case (m)
         2'b00: return f;
         2'b01: return q ^ f;
         2'b10: return (a && b) ? ~q : (a ? 1'b1 : (b ? 1'b0 : q));
         default: return (a && b) ? q : (a ? 1'b1 : (b ? 1'b0 : q));
      endcase
   endfunction

   function automatic string mode_tag(input logic [1:0] m, input logic en);
      if (!en) return "R10";
      case (m)
         2'b00: return "R6";
         2'b01: return "R7";
         2'b10: return "R8";
         default: return "R9";
      endcase
   endfunction

   initial begin
      #1_000_000;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", n_chk + 1, n_bad);
      $finish;
   end

   initial begin
      logic vq;
      logic a, b, f, nxt;
      // reset state
      #1;
      chk("R11 reset output", mc_out, 1'b0);
      cfg_preset = 1'b1;
      #1;
      chk("R12 reset output with preset", mc_out, 1'b1);
      cfg_preset = 1'b0;
      @(negedge clk);
      clr_n = 1'b1;

      // R1: exhaustive select/input sweep, term B forced to 0 by code 11
      cfg_bypass = 1'b1;
      sel_b = 8'b0000_0011;
      for (int s = 0; s < 256; s++) begin
         for (int v = 0; v < 16; v++) begin
            sel_a = s[7:0];
            in_bus = v[3:0];
            #1;
            chk("R1 term literal select", mc_out, ref_term(v[3:0], s[7:0]));
         end
      end

      // R2 R3 R4: merge, expander and inverter sweep
      sel_a = 8'b0000_0001;
      sel_b = 8'b0000_0100;
      for (int v = 0; v < 4; v++) begin
         for (int x = 0; x < 2; x++) begin
            for (int iv = 0; iv < 2; iv++) begin
               for (int p = 0; p < 2; p++) begin
                  logic ea, eb, es;
                  in_bus = {2'b00, v[1:0]};
                  cfg_xor = x[0];
                  cfg_inv = iv[0];
                  pexp_in = p[0];
                  #1;
                  ea = v[0];
                  eb = v[1];
                  es = (x[0] ? (ea ^ eb) : (ea | eb)) | p[0];
                  chk("R3 expander out", pexp_out, es);
                  chk(iv[0] ? "R4 inverted output" : "R2 merge output", mc_out, es ^ iv[0]);
               end
            end
         end
      end
      pexp_in = 1'b0;

      // R5..R12: register modes with random data
      for (int m = 0; m < 4; m++) begin
         for (int pr = 0; pr < 2; pr++) begin
            @(negedge clk);
            ff_mode = m[1:0];
            cfg_preset = pr[0];
            cfg_bypass = 1'b0;
            ena = 1'b1;
            #1;
            clr_n = 1'b0;
            #0.5;
            chk("R11 async clear mid-cycle", mc_out, pr[0]);
            @(negedge clk);
            chk(pr[0] ? "R12 clear with preset" : "R11 clear held over edge", mc_out, pr[0]);
            clr_n = 1'b1;
            vq = pr[0];
            for (int k = 0; k < 200; k++) begin
               logic [31:0] r;
               r = $urandom;
               in_bus = {2'b00, r[1:0]};
               cfg_xor = r[2];
               cfg_inv = r[3];
               ena = (r[6:4] != 3'b000);
               a = r[0];
               b = r[1];
               f = ((r[2] ? (a ^ b) : (a | b))) ^ r[3];
               #1;
               cfg_bypass = 1'b1;
               #0.2;
               chk("R5 bypass output", mc_out, f);
               cfg_bypass = 1'b0;
               #0.2;
               chk("R5 registered output before edge", mc_out, vq);
               nxt = ref_next(m[1:0], vq, a, b, f, ena);
               @(posedge clk);
               vq = nxt;
               @(negedge clk);
               chk(pr[0] ? {"R12 ", mode_tag(m[1:0], ena)} : mode_tag(m[1:0], ena), mc_out, vq);
            end
         end
      end

      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

endmodule